// File: doc/BRIEF.md
# Signed Carry-Save Array Multiplier

This block multiplies two two's complement operands of WIDTH bits and returns their full 2*WIDTH-bit product. The top operand bit has a weight of -2^(WIDTH-1). The block does not sign-extend the operands to handle sign. The AND-gate partial products that pair the top bit of one operand with a lower bit of the other are inverted. The partial product of the two top bits is left plain. The correction that this inversion needs is a pair of fixed ones, at weights 2^WIDTH and 2^(2*WIDTH-1), fed into the array.

The partial-product rows are folded one at a time by a linear chain of full-adder rows. Each row takes the running sum vector, the running carry vector and the next partial-product row as three operands. It returns a new sum vector and a new carry vector, and the carry vector is moved one place up because each carry has twice the weight of a sum bit. A single ripple carry-propagate adder joins the last two vectors.

A parameter selects whether the product leaves through a register with a synchronous active-high reset or straight from the adder.

Top module: `bw_mult`

## Requirements
- R1: `p` equals the two's complement product of `a` and `b`, reduced modulo 2^(2*WIDTH), for every pair of operand values.
- R2: The top operand bit weighs -2^(WIDTH-1). With WIDTH=8, 8'h80 times 8'h80 gives 16'h4000, and 8'h80 times 8'h7F gives 16'hC080.
- R3: When either operand is zero, `p` is zero.
- R4: When `b` is 1, `p` is `a` sign-extended to 2*WIDTH bits.
- R5: When `b` is all ones (-1), `p` is the negation of `a`. With WIDTH=8, 8'h80 times 8'hFF gives 16'h0080.
- R6: With OUT_REG=1, a clock edge that samples `rst` high clears `p` to zero, whatever the operands are.
- R7: With OUT_REG=1, `p` holds the product of the operands sampled at the last rising edge. A change on `a` or `b` between edges leaves `p` unchanged.
- R8: Bit 2*WIDTH-1 of `p` is set exactly when both operands are nonzero and their top bits differ.
- R9: With OUT_REG=0, `p` follows `a` and `b` with no clock edge, and `rst` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | Multiplicand, two's complement |
| b | input | WIDTH | Multiplier, two's complement |
| p | output | 2*WIDTH | Signed product |

## Verification
The bench builds two copies of the block with WIDTH=8: one with OUT_REG=1 and one with OUT_REG=0. Both copies are driven through all 65536 operand pairs, and each result is compared against integer arithmetic done in the bench. At eight bits this sweep reaches every combination of inverted partial products, both injected correction ones and every carry path through the array. That includes the most-negative-times-most-negative case and the -1 cases. The registered copy is also checked for the one-edge latency, for its output holding when inputs change between edges, and for a reset in the middle of the run.

// File: rtl/bw_pkg.sv
package bw_pkg;

    // How a partial-product bit is formed from its AND gate
    typedef enum logic [0:0] {
        PP_PLAIN    = 1'b0,
        PP_INVERTED = 1'b1
    } pp_kind_e;

    // Result of one 3:2 counter
    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    // A bit is inverted when exactly one of its two indices is the top bit
    function automatic pp_kind_e pp_kind(int row, int col, int w);
        return ((row == w - 1) != (col == w - 1)) ? PP_INVERTED : PP_PLAIN;
    endfunction

    function automatic fa_out_t full_add(logic x, logic y, logic z);
        fa_out_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // Pre-summed correction constant: ones at weights w and 2w-1
    function automatic logic fix_bit(int pos, int w);
        return (pos == w) || (pos == 2 * w - 1);
    endfunction

endpackage

// File: rtl/bw_ppgen.sv
module bw_ppgen
    import bw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [2*W-1:0]   rows [W],
    output logic [2*W-1:0]   fix_vec
);
    localparam int PW = 2 * W;

    for (genvar j = 0; j < W; j++) begin : g_row
        for (genvar k = 0; k < PW; k++) begin : g_bit
            if (k >= j && k < j + W) begin : g_pp
                if (pp_kind(j, k - j, W) == PP_INVERTED) begin : g_inv
                    assign rows[j][k] = ~(a[k-j] & b[j]);
                end else begin : g_and
                    assign rows[j][k] = a[k-j] & b[j];
                end
            end else begin : g_zero
                assign rows[j][k] = 1'b0;
            end
        end
    end

    for (genvar k = 0; k < PW; k++) begin : g_fix
        assign fix_vec[k] = fix_bit(k, W);
    end

endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row
    import bw_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    input  logic [PW-1:0] z,
    output logic [PW-1:0] sum,
    output logic [PW-1:0] carry
);
    assign carry[0] = 1'b0;

    for (genvar k = 0; k < PW; k++) begin : g_col
        if (k < PW - 1) begin : g_fa
            fa_out_t fo;
            assign fo         = full_add(x[k], y[k], z[k]);
            assign sum[k]     = fo.s;
            assign carry[k+1] = fo.c;
        end else begin : g_top
            assign sum[k] = x[k] ^ y[k] ^ z[k];
        end
    end

endmodule

// File: rtl/bw_csa_array.sv
module bw_csa_array #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] rows [W],
    input  logic [2*W-1:0] fix_vec,
    output logic [2*W-1:0] sum_vec,
    output logic [2*W-1:0] carry_vec
);
    localparam int PW = 2 * W;

    logic [PW-1:0] s_acc [W];
    logic [PW-1:0] c_acc [W];

    // The correction ones enter as the first carry vector, so no extra row is needed
    assign s_acc[0] = rows[0];
    assign c_acc[0] = fix_vec;

    for (genvar j = 1; j < W; j++) begin : g_stage
        bw_csa_row #(.PW(PW)) u_row (
            .x    (s_acc[j-1]),
            .y    (c_acc[j-1]),
            .z    (rows[j]),
            .sum  (s_acc[j]),
            .carry(c_acc[j])
        );
    end

    assign sum_vec   = s_acc[W-1];
    assign carry_vec = c_acc[W-1];

endmodule

// File: rtl/bw_cpa.sv
module bw_cpa
    import bw_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] s
);
    logic [PW-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar k = 0; k < PW; k++) begin : g_bit
        if (k < PW - 1) begin : g_fa
            fa_out_t fo;
            assign fo      = full_add(x[k], y[k], cy[k]);
            assign s[k]    = fo.s;
            assign cy[k+1] = fo.c;
        end else begin : g_top
            assign s[k] = x[k] ^ y[k] ^ cy[k];
        end
    end

endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [2*WIDTH-1:0] p
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] pp_rows [WIDTH];
    logic [PW-1:0] fix_vec;
    logic [PW-1:0] red_sum;
    logic [PW-1:0] red_carry;
    logic [PW-1:0] prod;
    logic [PW-1:0] prod_q;

    bw_ppgen #(.W(WIDTH)) u_ppgen (
        .a      (a),
        .b      (b),
        .rows   (pp_rows),
        .fix_vec(fix_vec)
    );

    bw_csa_array #(.W(WIDTH)) u_array (
        .rows     (pp_rows),
        .fix_vec  (fix_vec),
        .sum_vec  (red_sum),
        .carry_vec(red_carry)
    );

    bw_cpa #(.PW(PW)) u_cpa (
        .x(red_sum),
        .y(red_carry),
        .s(prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q <= prod;
        end
    end

    assign p = OUT_REG ? prod_q : prod;

endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [WIDTH-1:0]   a,
    input logic [WIDTH-1:0]   b,
    input logic [2*WIDTH-1:0] p
);
    localparam int PW = 2 * WIDTH;

    function automatic logic [PW-1:0] ref_mul(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
        logic signed [PW-1:0] xs;
        logic signed [PW-1:0] ys;
        xs = {{WIDTH{x[WIDTH-1]}}, x};
        ys = {{WIDTH{y[WIDTH-1]}}, y};
        return xs * ys;
    endfunction

    function automatic logic neg_expected(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y);
        return (x != '0) && (y != '0) && (x[WIDTH-1] != y[WIDTH-1]);
    endfunction

    if (OUT_REG) begin : g_reg
        // R1
        reg_prod_match_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> p == ref_mul($past(a), $past(b)));
        // R3
        reg_zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ($past(a) == '0 || $past(b) == '0)) |-> p == '0);
        // R8
        reg_sign_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> p[PW-1] == neg_expected($past(a), $past(b)));
        // R6
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> p == '0);
    end else begin : g_comb
        // R9
        comb_prod_match_chk: assert property (@(posedge clk) disable iff (rst)
            p == ref_mul(a, b));
        // R3
        comb_zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
            (a == '0 || b == '0) |-> p == '0);
        // R8
        comb_sign_chk: assert property (@(posedge clk) disable iff (rst)
            p[PW-1] == neg_expected(a, b));
    end

endmodule

bind bw_mult bw_mult_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk),
    .rst(rst),
    .a  (a),
    .b  (b),
    .p  (p)
);

// File: tb/test_bw_mult.sv
module test_bw_mult;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a   = '0;
    logic [W-1:0]  b   = '0;
    logic [PW-1:0] p_r;
    logic [PW-1:0] p_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bw_mult #(.WIDTH(W), .OUT_REG(1'b1)) i_bw_mult (
        .clk(clk), .rst(rst), .a(a), .b(b), .p(p_r)
    );

    bw_mult #(.WIDTH(W), .OUT_REG(1'b0)) i_bw_mult_comb (
        .clk(clk), .rst(rst), .a(a), .b(b), .p(p_c)
    );

    function automatic logic [PW-1:0] expect_prod(logic [W-1:0] x, logic [W-1:0] y);
        int xi;
        int yi;
        xi = int'($signed(x));
        yi = int'($signed(y));
        return PW'(xi * yi);
    endfunction

    function automatic logic expect_neg(logic [W-1:0] x, logic [W-1:0] y);
        int xi;
        int yi;
        xi = int'($signed(x));
        yi = int'($signed(y));
        return (xi * yi) < 0;
    endfunction

    function automatic string tag_for(logic [W-1:0] x, logic [W-1:0] y);
        if (x == '0 || y == '0)         return "R3";
        else if (y == 8'h01)            return "R4";
        else if (y == 8'hFF)            return "R5";
        else if (x == 8'h80 || y == 8'h80) return "R2";
        else                            return "R1";
    endfunction

    task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [PW-1:0] prev_exp;
        string         prev_tag;
        bit            have_prev;
        logic [PW-1:0] e;
        string         t;

        have_prev = 1'b0;
        prev_exp  = '0;
        prev_tag  = "R1";

        // Reset state: registered copy cleared, combinational copy live (R6, R9)
        a = 8'h5A;
        b = 8'h33;
        @(negedge clk);
        @(negedge clk);
        check("R6", p_r, '0);
        check("R9", p_c, expect_prod(a, b));
        rst = 1'b0;

        // Exhaustive sweep over all operand pairs
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                @(negedge clk);
                if (have_prev) check(prev_tag, p_r, prev_exp);
                a = W'(ai);
                b = W'(bi);
                #1;
                e = expect_prod(a, b);
                t = tag_for(a, b);
                check(t, p_c, e);
                check("R8", PW'(p_c[PW-1]), PW'(expect_neg(a, b)));
                if (have_prev) check("R7", p_r, prev_exp);
                prev_exp  = e;
                prev_tag  = t;
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check(prev_tag, p_r, prev_exp);

        // Fixed corner values, independent of the arithmetic model
        a = 8'h80; b = 8'h80; #1;
        check("R2", p_c, 16'h4000);
        a = 8'h80; b = 8'h7F; #1;
        check("R2", p_c, 16'hC080);
        a = 8'h80; b = 8'hFF; #1;
        check("R5", p_c, 16'h0080);
        a = 8'h85; b = 8'h01; #1;
        check("R4", p_c, 16'hFF85);

        // Mid-run reset of the registered copy (R6), combinational copy unaffected (R9)
        @(negedge clk);
        a   = 8'h7F;
        b   = 8'h7F;
        rst = 1'b1;
        @(negedge clk);
        check("R6", p_r, '0);
        check("R9", p_c, 16'h3F01);
        rst = 1'b0;
        @(negedge clk);
        check("R1", p_r, 16'h3F01);

        finish_run();
    end

endmodule